// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Hardware Flow Control

This block sends and receives asynchronous serial frames. The transmit path holds one byte in a holding register. When the line is idle it moves that byte into a shift register and sends it as a frame. The receive path oversamples the incoming line at sixteen times the bit rate and decides each bit by a majority vote at mid-bit. It keeps the received byte in a one-entry receive register and records overrun, framing and parity errors in sticky flags.

Flow control works in one direction at a time, chosen by a mode input. In CTS mode, with gating enabled, the transmitter starts a new frame only while the peer holds the clear-to-send input low. A frame that has already begun always completes. In RTS mode the block drives a ready-to-receive output low only when the receiver is enabled, idle, empty and free of errors. In every other case that output is high.

Top module: `uart_fc`

## Requirements
- R1: Each transmitted frame is one start bit (0), eight data bits least significant bit first, an optional parity bit when `par_en_i`=1, and one stop bit (1). Each bit lasts 16*(`div_i`+1) clock cycles. `txd_o` is 1 whenever no frame is being sent. With `par_odd_i`=0 the parity bit makes the count of ones over data and parity even. With `par_odd_i`=1 it makes that count odd.
- R2: With `cts_en_i`=1 and `fc_mode_i`=0, a pending byte starts a frame only while `cts_ni`, seen through a two-flop synchronizer, is low. While `cts_ni` is high the byte waits and `tx_full_o` stays 1.
- R3: With `cts_en_i`=0, or with `fc_mode_i`=1, the level of `cts_ni` has no effect and a pending byte is sent at once.
- R4: If `cts_ni` rises while a frame is being sent, that frame completes with its stop bit. The next pending byte then waits until `cts_ni` is low again.
- R5: With `fc_mode_i`=1, `rts_no` is low one cycle after all of these hold at once: `rx_en_i`=1, `rx_busy_o`=0, `rx_valid_o`=0, and `ovr_o`, `frm_o` and `par_o` all 0. Otherwise it is high. While `rx_en_i`=0, the receiver ignores `rxd_i`.
- R6: With `fc_mode_i`=0, `rts_no` is held high.
- R7: A completed frame sets `rx_valid_o` and puts its byte on `rx_data_o`. A one-cycle `rx_rd_i` pulse clears `rx_valid_o`.
- R8: A frame that completes while `rx_valid_o`=1 sets `ovr_o` and is discarded. `rx_data_o` keeps the earlier byte.
- R9: A stop bit sampled as 0 sets `frm_o` at the end of the stop bit. Every error flag stays set until a pulse on `err_clr_i`.
- R10: With `par_en_i`=1, a received parity bit that does not match the parity chosen by `par_odd_i` sets `par_o`.
- R11: A `tx_wr_i` pulse while `tx_full_o`=1 is ignored. The held byte is not changed and no extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Clock cycles per oversample tick, minus one |
| par_en_i | input | 1 | Adds and checks a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| fc_mode_i | input | 1 | 0 selects CTS gating, 1 selects RTS generation |
| cts_en_i | input | 1 | Enables CTS gating in CTS mode |
| rx_en_i | input | 1 | Enables the receiver |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Loads `tx_data_i` into the holding register |
| tx_full_o | output | 1 | Holding register occupied |
| tx_busy_o | output | 1 | Frame being transmitted |
| txd_o | output | 1 | Serial transmit line |
| cts_ni | input | 1 | Clear to send from the peer, active low |
| rxd_i | input | 1 | Serial receive line |
| rts_no | output | 1 | Ready to receive to the peer, active low |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Unread byte present |
| rx_rd_i | input | 1 | Marks the received byte as read |
| rx_busy_o | output | 1 | Frame being received |
| err_clr_i | input | 1 | Clears all error flags |
| ovr_o | output | 1 | Overrun flag |
| frm_o | output | 1 | Framing error flag |
| par_o | output | 1 | Parity error flag |

## Verification
A wrong receive state shows up on `rts_no` one clock after it arises. A stuck busy flag, a lost unread bit or an error flag that fails to clear each leaves the peer either blocked or invited to send into a full register. A wrong transmit state machine or bit counter corrupts the very next frame on `txd_o`, and sampling the line at mid-bit exposes that within one bit period. A CTS gate applied at the wrong moment shows in two ways: a frame cut short, or a byte that leaves while `tx_full_o` should still hold it. The difference appears within one bit time of the change on `cts_ni`.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } frame_st_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_fc_baud.sv
module uart_fc_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              gate_i,
  input  logic              cts_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned TCNT_W = $clog2(OVS);
  localparam int unsigned BCNT_W = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] T_LAST = TCNT_W'(OVS - 1);
  localparam logic [BCNT_W-1:0] B_LAST = BCNT_W'(DATA_W - 1);

  frame_st_e         st_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              full_q, par_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              can_start, bit_end;

  // gate is evaluated only when idle with a pending byte
  assign can_start = (st_q == ST_IDLE) && full_q && !(gate_i && cts_i);
  assign bit_end   = tick_i && (tcnt_q == T_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      par_q  <= 1'b0;
      tcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (wr_i && !full_q) begin
        hold_q <= data_i;
        full_q <= 1'b1;
      end
      if (can_start) begin
        sh_q   <= hold_q;
        par_q  <= (^hold_q) ^ par_odd_i;
        full_q <= 1'b0;
        tcnt_q <= '0;
        bcnt_q <= '0;
        st_q   <= ST_START;
      end else if (tick_i && st_q != ST_IDLE) begin
        tcnt_q <= tcnt_q + 1'b1;
        if (bit_end) begin
          unique case (st_q)
            ST_START: st_q <= ST_DATA;
            ST_DATA: begin
              sh_q <= sh_q >> 1;
              if (bcnt_q == B_LAST) st_q <= par_en_i ? ST_PAR : ST_STOP;
              else                  bcnt_q <= bcnt_q + 1'b1;
            end
            ST_PAR:  st_q <= ST_STOP;
            ST_STOP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign full_o = full_q;
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o
);
  localparam int unsigned TCNT_W = $clog2(OVS);
  localparam int unsigned BCNT_W = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] T_LAST = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] T_MID  = TCNT_W'(OVS / 2);
  localparam logic [BCNT_W-1:0] B_LAST = BCNT_W'(DATA_W - 1);

  frame_st_e         st_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [2:0]        smp_q;
  logic              pbit_q, valid_q, ovr_q, frm_q, perr_q;
  logic              maj, in_win, bit_end, done, bad_par, bad_stop;

  assign maj      = maj3(smp_q);
  assign in_win   = (tcnt_q >= T_MID - 1'b1) && (tcnt_q <= T_MID + 1'b1);
  assign bit_end  = tick_i && (tcnt_q == T_LAST);
  assign done     = bit_end && (st_q == ST_STOP);
  assign bad_stop = !maj;
  assign bad_par  = par_en_i && (pbit_q != ((^sh_q) ^ par_odd_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      tcnt_q <= '0;
      bcnt_q <= '0;
      smp_q  <= '1;
      pbit_q <= 1'b0;
    end else if (!en_i) begin
      st_q <= ST_IDLE;
    end else if (tick_i) begin
      if (st_q == ST_IDLE) begin
        if (!rxd_i) begin
          st_q   <= ST_START;
          tcnt_q <= '0;
          bcnt_q <= '0;
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
        if (in_win) smp_q <= {smp_q[1:0], rxd_i};
        if (bit_end) begin
          unique case (st_q)
            ST_START: st_q <= maj ? ST_IDLE : ST_DATA;  // false start
            ST_DATA: begin
              sh_q <= {maj, sh_q[DATA_W-1:1]};
              if (bcnt_q == B_LAST) st_q <= par_en_i ? ST_PAR : ST_STOP;
              else                  bcnt_q <= bcnt_q + 1'b1;
            end
            ST_PAR: begin
              pbit_q <= maj;
              st_q   <= ST_STOP;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      if (rd_i) valid_q <= 1'b0;
      if (clr_i) begin
        ovr_q  <= 1'b0;
        frm_q  <= 1'b0;
        perr_q <= 1'b0;
      end
      if (done) begin
        if (bad_stop) frm_q  <= 1'b1;
        if (bad_par)  perr_q <= 1'b1;
        if (valid_q && !rd_i) begin
          ovr_q <= 1'b1;
        end else begin
          data_q  <= sh_q;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign ovr_o   = ovr_q;
  assign frm_o   = frm_q;
  assign par_o   = perr_q;
endmodule

// File: rtl/uart_fc.sv
module uart_fc #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              fc_mode_i,
  input  logic              cts_en_i,
  input  logic              rx_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic              tx_full_o,
  output logic              tx_busy_o,
  output logic              txd_o,
  input  logic              cts_ni,
  input  logic              rxd_i,
  output logic              rts_no,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_rd_i,
  output logic              rx_busy_o,
  input  logic              err_clr_i,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o
);
  logic tick, cts_s, rxd_s, rx_ready, rts_q;

  uart_fc_sync #(.STAGES(2), .RST(1'b1)) i_sync_cts (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_ni), .q_o(cts_s));

  uart_fc_sync #(.STAGES(2), .RST(1'b1)) i_sync_rxd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s));

  uart_fc_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick));

  uart_fc_tx #(.DATA_W(DATA_W), .OVS(OVS)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .gate_i   (cts_en_i && !fc_mode_i),
    .cts_i    (cts_s),
    .wr_i     (tx_wr_i),
    .data_i   (tx_data_i),
    .full_o   (tx_full_o),
    .busy_o   (tx_busy_o),
    .txd_o    (txd_o)
  );

  uart_fc_rx #(.DATA_W(DATA_W), .OVS(OVS)) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .en_i     (rx_en_i),
    .rxd_i    (rxd_s),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .rd_i     (rx_rd_i),
    .clr_i    (err_clr_i),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o),
    .busy_o   (rx_busy_o),
    .ovr_o    (ovr_o),
    .frm_o    (frm_o),
    .par_o    (par_o)
  );

  assign rx_ready = fc_mode_i && rx_en_i && !rx_busy_o && !rx_valid_o &&
                    !ovr_o && !frm_o && !par_o;

  // registered so the pin never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_q <= 1'b1;
    else         rts_q <= !rx_ready;
  end

  assign rts_no = rts_q;
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fc_mode_i,
  input logic cts_en_i,
  input logic cts_s,
  input logic tx_busy_o,
  input logic txd_o,
  input logic rts_no,
  input logic rx_busy_o,
  input logic rx_valid_o,
  input logic ovr_o,
  input logic frm_o,
  input logic par_o
);
  a_r1_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> txd_o);

  a_r2_cts_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> !$past(cts_en_i && !fc_mode_i && cts_s));

  a_r5_busy_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_busy_o |=> rts_no);

  a_r5_unread_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> rts_no);

  a_r5_err_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o || frm_o || par_o) |=> rts_no);

  a_r6_mode_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fc_mode_i |=> rts_no);

  a_r8_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(rx_valid_o));
endmodule

bind uart_fc uart_fc_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fc_mode_i (fc_mode_i),
  .cts_en_i  (cts_en_i),
  .cts_s     (cts_s),
  .tx_busy_o (tx_busy_o),
  .txd_o     (txd_o),
  .rts_no    (rts_no),
  .rx_busy_o (rx_busy_o),
  .rx_valid_o(rx_valid_o),
  .ovr_o     (ovr_o),
  .frm_o     (frm_o),
  .par_o     (par_o)
);

// File: tb/test_uart_fc.sv
module test_uart_fc;
  localparam int DIV = 3;
  localparam int BIT = 16 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div = 16'(DIV);
  logic        par_en = 1'b0, par_odd = 1'b0, fc_mode = 1'b0, cts_en = 1'b0, rx_en = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_wr = 1'b0, cts_n = 1'b1, rxd = 1'b1, rx_rd = 1'b0, err_clr = 1'b0;
  logic        tx_full, tx_busy, txd, rts_n, rx_valid, rx_busy, ovr, frm, perr;
  logic [7:0]  rx_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_fc i_uart_fc (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .par_en_i(par_en), .par_odd_i(par_odd),
    .fc_mode_i(fc_mode), .cts_en_i(cts_en), .rx_en_i(rx_en), .tx_data_i(tx_data),
    .tx_wr_i(tx_wr), .tx_full_o(tx_full), .tx_busy_o(tx_busy), .txd_o(txd),
    .cts_ni(cts_n), .rxd_i(rxd), .rts_no(rts_n), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_rd_i(rx_rd), .rx_busy_o(rx_busy), .err_clr_i(err_clr),
    .ovr_o(ovr), .frm_o(frm), .par_o(perr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; clks(1); tx_wr = 1'b0;
  endtask

  // captures one frame from txd at mid-bit; found=0 if no start within limit
  task automatic cap_tx(input bit with_par, input int limit, output logic [7:0] d,
                        output logic pb, output logic stp, output bit found);
    int w = 0;
    found = 1'b0; d = '0; pb = 1'b0; stp = 1'b0;
    while (txd && w < limit) begin clks(1); w++; end
    if (!txd) begin
      found = 1'b1;
      clks(BIT / 2);
      for (int i = 0; i < 8; i++) begin clks(BIT); d[i] = txd; end
      if (with_par) begin clks(BIT); pb = txd; end
      clks(BIT); stp = txd;
      clks(BIT / 2);
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input bit with_par, input logic pb, input logic stp);
    rxd = 1'b0; clks(BIT);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; clks(BIT); end
    if (with_par) begin rxd = pb; clks(BIT); end
    rxd = stp; clks(BIT);
    rxd = 1'b1; clks(20);
  endtask

  task automatic pulse_rd();
    rx_rd = 1'b1; clks(1); rx_rd = 1'b0; clks(1);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; clks(1); err_clr = 1'b0; clks(2);
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(tx_full === 1'b0, "R11 reset full", tx_full, 0);
    chk(rx_valid === 1'b0, "R7 reset valid", rx_valid, 0);
    chk(rts_n === 1'b1, "R6 reset rts", rts_n, 1);
  endtask

  task automatic t_tx_free();
    logic [7:0] d; logic pb, s; bit f;
    fc_mode = 1'b0; cts_en = 1'b0; cts_n = 1'b1;  // R3: cts high but gating off
    wr_tx(8'hA5);
    cap_tx(1'b0, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'hA5, "R3 frame sent with cts high, gate off", d, 8'hA5);
    chk(s === 1'b1, "R1 stop bit", s, 1);
    fc_mode = 1'b1; cts_en = 1'b1;                // R3: RTS mode ignores cts
    wr_tx(8'h5C);
    cap_tx(1'b0, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'h5C, "R3 frame sent in rts mode", d, 8'h5C);
    fc_mode = 1'b0; cts_en = 1'b0;
  endtask

  task automatic t_tx_parity();
    logic [7:0] d; logic pb, s; bit f;
    par_en = 1'b1; par_odd = 1'b1;
    wr_tx(8'h03);
    cap_tx(1'b1, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'h03 && pb === 1'b1 && s === 1'b1, "R1 odd parity frame", {pb, d}, 9'h103);
    par_odd = 1'b0;
    wr_tx(8'h07);
    cap_tx(1'b1, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'h07 && pb === 1'b1, "R1 even parity frame", {pb, d}, 9'h107);
    par_en = 1'b0;
  endtask

  task automatic t_cts_hold();
    logic [7:0] d; logic pb, s; bit f;
    cts_en = 1'b1; cts_n = 1'b1;
    wr_tx(8'h3C);
    clks(5 * BIT);
    chk(txd === 1'b1 && tx_full === 1'b1, "R2 held while cts high", {tx_full, txd}, 2'b11);
    cts_n = 1'b0;
    cap_tx(1'b0, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'h3C, "R2 sent after cts low", d, 8'h3C);
  endtask

  task automatic t_cts_midframe();
    logic [7:0] d; logic pb, s; bit f;
    int w = 0;
    cts_en = 1'b1; cts_n = 1'b0;
    wr_tx(8'hC3);
    while (tx_full && w < 1000) begin clks(1); w++; end
    wr_tx(8'h96);
    fork
      cap_tx(1'b0, 4 * BIT, d, pb, s, f);
      begin clks(3 * BIT); cts_n = 1'b1; end
    join
    chk(f && d == 8'hC3 && s === 1'b1, "R4 frame completes after cts rise", d, 8'hC3);
    clks(4 * BIT);
    chk(txd === 1'b1 && tx_full === 1'b1, "R4 next frame held", {tx_full, txd}, 2'b11);
    cts_n = 1'b0;
    cap_tx(1'b0, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'h96, "R4 next frame after cts low", d, 8'h96);
  endtask

  task automatic t_wr_full();
    logic [7:0] d; logic pb, s; bit f;
    cts_en = 1'b1; cts_n = 1'b1;
    wr_tx(8'h11);
    wr_tx(8'h22);
    cts_n = 1'b0;
    cap_tx(1'b0, 4 * BIT, d, pb, s, f);
    chk(f && d == 8'h11, "R11 held byte kept", d, 8'h11);
    cap_tx(1'b0, 3 * BIT, d, pb, s, f);
    chk(!f && tx_full === 1'b0, "R11 no extra frame", f, 0);
    cts_en = 1'b0;
  endtask

  task automatic t_rx_basic();
    fc_mode = 1'b1; rx_en = 1'b1; clks(3);
    chk(rts_n === 1'b0, "R5 idle ready rts low", rts_n, 0);
    fork
      send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
      begin clks(3 * BIT); chk(rts_n === 1'b1, "R5 busy rts high", rts_n, 1); end
    join
    chk(rx_valid === 1'b1 && rx_data == 8'h5A, "R7 byte received", rx_data, 8'h5A);
    chk(rts_n === 1'b1, "R5 unread rts high", rts_n, 1);
    pulse_rd();
    chk(rx_valid === 1'b0, "R7 read clears valid", rx_valid, 0);
    clks(1);
    chk(rts_n === 1'b0, "R5 rts low after read", rts_n, 0);
  endtask

  task automatic t_overrun();
    send_rx(8'h11, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b0, 1'b1);
    chk(ovr === 1'b1, "R8 overrun flag", ovr, 1);
    chk(rx_data == 8'h11, "R8 old byte kept", rx_data, 8'h11);
    pulse_rd();
    clks(2);
    chk(rts_n === 1'b1, "R5 error keeps rts high", rts_n, 1);
    pulse_clr();
    chk(ovr === 1'b0 && rts_n === 1'b0, "R9 clear pulse", {ovr, rts_n}, 0);
  endtask

  task automatic t_frame_err();
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);
    clks(BIT);
    chk(frm === 1'b1, "R9 framing error", frm, 1);
    pulse_rd();
    clks(BIT);
    chk(frm === 1'b1 && rts_n === 1'b1, "R9 flag sticky", {frm, rts_n}, 2'b11);
    pulse_clr();
    chk(frm === 1'b0 && rts_n === 1'b0, "R9 cleared", {frm, rts_n}, 0);
  endtask

  task automatic t_parity_err();
    par_en = 1'b1; par_odd = 1'b0;
    send_rx(8'h07, 1'b1, 1'b0, 1'b1);
    chk(perr === 1'b1, "R10 parity mismatch", perr, 1);
    pulse_rd(); pulse_clr();
    send_rx(8'h07, 1'b1, 1'b1, 1'b1);
    chk(perr === 1'b0 && rx_data == 8'h07, "R10 good parity", {perr, rx_data}, 8'h07);
    pulse_rd();
    par_en = 1'b0;
  endtask

  task automatic t_rx_disabled();
    rx_en = 1'b0; clks(3);
    chk(rts_n === 1'b1, "R5 disabled rts high", rts_n, 1);
    send_rx(8'h33, 1'b0, 1'b0, 1'b1);
    chk(rx_valid === 1'b0, "R5 disabled receiver ignores line", rx_valid, 0);
    rx_en = 1'b1; clks(3);
  endtask

  task automatic t_mode0_rts();
    fc_mode = 1'b0; clks(3);
    chk(rts_n === 1'b1, "R6 cts mode rts high", rts_n, 1);
  endtask

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(3);
    t_reset();
    t_tx_free();
    t_tx_parity();
    t_cts_hold();
    t_cts_midframe();
    t_wr_full();
    t_rx_basic();
    t_overrun();
    t_frame_err();
    t_parity_err();
    t_rx_disabled();
    t_mode0_rts();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule